// File: doc/BRIEF.md
# Serial Display-RAM Slave Port

This block is the host-facing port of a segment display controller. A host talks to it over three wires plus a read strobe. These are an active-low select, a write strobe, a read strobe and one data line that the block can drive. Every transfer begins with a three-bit frame code, and that code picks one of three kinds of frame. A data frame moves 4-bit nibbles to or from a 256-entry nibble memory held inside the block. A read-modify-write frame returns a nibble and then replaces it. A command frame streams 8-bit control codes to the surrounding controller.

All pins are sampled with the system clock through two-stage synchronisers. Edges of the strobes are found on the synchronised copies. A data frame carries one 8-bit start address, sent most significant bit first. Nibbles then follow, each sent least significant bit first, and the address steps after every nibble for as long as select stays low. Command words are nine write clocks long, and later words in the same select window need no frame code. The block offers the data line as an output value plus an enable for an external tristate pad.

Top module: `seg_ram_link`

## Requirements
- R1: While `cs_n` is high no RAM write and no command is produced, and the frame logic returns to waiting for a frame code; a new frame is decoded only after `cs_n` falls.
- R2: The first three bits after select falls, taken most significant bit first, form the frame code: 3'b110 selects read, 3'b101 selects write (which also serves read-modify-write), 3'b100 selects command; any other code is ignored until `cs_n` rises again.
- R3: Write data is captured on the rising edge of `wr_n`; the 8-bit address arrives most significant bit first, and the k-th data bit sent in a nibble is stored in nibble bit k (least significant first).
- R4: After every complete nibble, read or written, the address increases by one, so a stream of nibbles in one select window reaches consecutive addresses.
- R5: The address wraps from 255 to 0.
- R6: In a read frame each rising edge of `rd_n` puts the next nibble bit (bit 0 first) on `dat_o`; `dat_oe` is 1 only in a read-data phase and is 0 during the frame code, the address and while `cs_n` is high.
- R7: In a write frame, a `rd_n` rising edge at a nibble boundary starts a read-modify-write: the nibble at the current address is shifted out on `rd_n` edges, then the four `wr_n` bits that follow overwrite that same address, and only then does the address step.
- R8: A command word is nine `wr_n` bits: the first eight, most significant first, become `cmd_code`, and the ninth is ignored; `cmd_valid` pulses for one clock per word, and further words in the same select window need no frame code.
- R9: If `cs_n` rises before a nibble or command word is complete, the partial bits are dropped and no RAM write or command pulse results.
- R10: Each completed written nibble gives a one-clock `ram_we` pulse with `ram_waddr` and `ram_wdata`; after reset `dat_oe`, `ram_we` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from host |
| wr_n | input | 1 | Write strobe, data taken on rising edge |
| rd_n | input | 1 | Read strobe, data driven on rising edge |
| dat_i | input | 1 | Value seen on the data pad |
| dat_o | output | 1 | Value to drive on the data pad |
| dat_oe | output | 1 | Enable for the data pad driver |
| cmd_valid | output | 1 | One-clock command pulse |
| cmd_code | output | 8 | Decoded command code |
| ram_we | output | 1 | One-clock nibble write pulse |
| ram_waddr | output | 8 | Address of the nibble written |
| ram_wdata | output | 4 | Nibble written |

## Verification
The bench builds the block at its default sizes: an 8-bit address, 4-bit nibbles, 8-bit command codes and two synchroniser stages. With 256 entries the wrap from 255 to 0 takes a single three-nibble frame, so the bench covers it next to ordinary addresses. With two synchroniser stages a strobe edge reaches the outputs in about four clocks. That lets each bench strobe phase of six clocks check single bits, including a select that rises partway through a nibble or a command word.

// File: rtl/seg_link_pkg.sv
package seg_link_pkg;

  typedef enum logic [2:0] {
    ST_CODE,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_RMW_RD,
    ST_CMD,
    ST_SKIP
  } frame_st_t;

  localparam logic [2:0] CODE_READ  = 3'b110;
  localparam logic [2:0] CODE_WRITE = 3'b101;
  localparam logic [2:0] CODE_CMD   = 3'b100;

endpackage

// File: rtl/seg_strobe_sync.sv
module seg_strobe_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = sh[STAGES-1];
  end

endmodule

// File: rtl/seg_nibble_ram.sv
module seg_nibble_ram #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/seg_frame_ctrl.sv
module seg_frame_ctrl
  import seg_link_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 4,
  parameter int IDW = 3,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          wr_s,
  input  logic          rd_s,
  input  logic          dat_s,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          dat_o,
  output logic          dat_oe,
  output logic          cmd_valid,
  output logic [CW-1:0] cmd_code
);

  localparam int MAXB0 = (CW + 1 > AW) ? CW + 1 : AW;
  localparam int MAXB  = (MAXB0 > IDW) ? MAXB0 : IDW;
  localparam int CNTW  = $clog2(MAXB + 1);
  localparam int NIW   = $clog2(DW);
  localparam logic [CNTW-1:0] CODE_LAST = CNTW'(IDW - 1);
  localparam logic [CNTW-1:0] ADDR_LAST = CNTW'(AW - 1);
  localparam logic [CNTW-1:0] NIB_LAST  = CNTW'(DW - 1);
  localparam logic [CNTW-1:0] CMD_BITS  = CNTW'(CW);

  frame_st_t       st;
  logic [CNTW-1:0] cnt;
  logic [IDW-1:0]  code_sh;
  logic [CW-1:0]   cmd_sh;
  logic [DW-1:0]   nib;
  logic            is_read;
  logic            wr_q, rd_q;
  logic            wr_rise, rd_rise;
  logic [IDW-1:0]  code_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_s;
      rd_q <= rd_s;
    end
  end

  assign wr_rise  = wr_s & ~wr_q;
  assign rd_rise  = rd_s & ~rd_q;
  assign code_now = {code_sh[IDW-2:0], dat_s};

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      st        <= ST_CODE;
      cnt       <= '0;
      code_sh   <= '0;
      cmd_sh    <= '0;
      nib       <= '0;
      is_read   <= 1'b0;
      we        <= 1'b0;
      cmd_valid <= 1'b0;
      dat_oe    <= 1'b0;
      dat_o     <= 1'b0;
      if (rst) begin
        addr     <= '0;
        waddr    <= '0;
        wdata    <= '0;
        cmd_code <= '0;
      end
    end else begin
      we        <= 1'b0;
      cmd_valid <= 1'b0;
      case (st)
        ST_CODE: if (wr_rise) begin
          code_sh <= code_now;
          if (cnt == CODE_LAST) begin
            cnt     <= '0;
            is_read <= (code_now == CODE_READ);
            if (code_now == CODE_READ || code_now == CODE_WRITE) st <= ST_ADDR;
            else if (code_now == CODE_CMD)                        st <= ST_CMD;
            else                                                  st <= ST_SKIP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: if (wr_rise) begin
          addr <= {addr[AW-2:0], dat_s};
          if (cnt == ADDR_LAST) begin
            cnt    <= '0;
            st     <= is_read ? ST_RD : ST_WR;
            dat_oe <= is_read;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD: if (rd_rise) begin
          dat_o <= rdata[cnt[NIW-1:0]];
          if (cnt == NIB_LAST) begin
            cnt  <= '0;
            addr <= addr + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WR: begin
          if (wr_rise) begin
            nib[cnt[NIW-1:0]] <= dat_s;
            if (cnt == NIB_LAST) begin
              cnt   <= '0;
              we    <= 1'b1;
              waddr <= addr;
              wdata <= {dat_s, nib[DW-2:0]};
              addr  <= addr + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (rd_rise && cnt == '0) begin
            st     <= ST_RMW_RD;
            dat_oe <= 1'b1;
            dat_o  <= rdata[0];
            cnt    <= CNTW'(1);
          end
        end
        ST_RMW_RD: begin
          if (wr_rise) begin
            st     <= ST_WR;
            dat_oe <= 1'b0;
            nib[0] <= dat_s;
            cnt    <= CNTW'(1);
          end else if (rd_rise) begin
            dat_o <= rdata[cnt[NIW-1:0]];
            cnt   <= (cnt == NIB_LAST) ? '0 : cnt + 1'b1;
          end
        end
        ST_CMD: if (wr_rise) begin
          if (cnt < CMD_BITS) begin
            cmd_sh <= {cmd_sh[CW-2:0], dat_s};
            cnt    <= cnt + 1'b1;
          end else begin
            cmd_valid <= 1'b1;
            cmd_code  <= cmd_sh;
            cnt       <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) we |=> !we) else $error("we longer than one clock"); // R10
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst) cmd_valid |=> !cmd_valid) else $error("cmd pulse too long"); // R8
  AST_WE_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) we |-> addr == AW'(waddr + 1'b1)) else $error("address did not step"); // R4
  AST_OE_CS_IDLE: assert property (@(posedge clk) disable iff (rst) $past(cs_s) |-> !dat_oe) else $error("driving while idle"); // R6
  AST_NO_WE_CS_IDLE: assert property (@(posedge clk) disable iff (rst) $past(cs_s) |-> !we) else $error("write while idle"); // R1
  AST_NO_CMD_CS_IDLE: assert property (@(posedge clk) disable iff (rst) $past(cs_s) |-> !cmd_valid) else $error("command while idle"); // R9

endmodule

// File: rtl/seg_ram_link.sv
module seg_ram_link #(
  parameter int AW          = 8,
  parameter int DW          = 4,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          dat_i,
  output logic          dat_o,
  output logic          dat_oe,
  output logic          cmd_valid,
  output logic [CW-1:0] cmd_code,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata
);

  localparam int NPIN = 4;

  logic [NPIN-1:0] pins_s;
  logic [AW-1:0]   rd_addr;
  logic [DW-1:0]   rd_data;

  seg_strobe_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({dat_i, rd_n, wr_n, cs_n}),
    .d_out (pins_s)
  );

  seg_frame_ctrl #(.AW(AW), .DW(DW), .IDW(3), .CW(CW)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (pins_s[0]),
    .wr_s      (pins_s[1]),
    .rd_s      (pins_s[2]),
    .dat_s     (pins_s[3]),
    .rdata     (rd_data),
    .addr      (rd_addr),
    .we        (ram_we),
    .waddr     (ram_waddr),
    .wdata     (ram_wdata),
    .dat_o     (dat_o),
    .dat_oe    (dat_oe),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );

  seg_nibble_ram #(.AW(AW), .DW(DW)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

endmodule

// File: tb/test_seg_ram_link.sv
module test_seg_ram_link;

  logic clk = 1'b0;
  logic rst, cs_n, wr_n, rd_n, dat_i;
  logic dat_o, dat_oe, cmd_valid, ram_we;
  logic [7:0] cmd_code, ram_waddr;
  logic [3:0] ram_wdata;

  int total = 0;
  int bad   = 0;
  int wcnt  = 0;
  int ccnt  = 0;
  logic [7:0] lw_a, lc;
  logic [3:0] lw_d;
  logic [3:0] got;

  always #5 clk = ~clk;

  seg_ram_link i_seg_ram_link (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .dat_i(dat_i),
    .dat_o(dat_o), .dat_oe(dat_oe), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  always @(negedge clk) begin
    if (ram_we) begin wcnt++; lw_a = ram_waddr; lw_d = ram_wdata; end
    if (cmd_valid) begin ccnt++; lc = cmd_code; end
  end

  localparam logic [11:0] VEC [6] = '{
    {8'h00, 4'h5}, {8'h81, 4'hA}, {8'h3C, 4'h1},
    {8'hFD, 4'h8}, {8'h7F, 4'hF}, {8'hC3, 4'h6}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pause();
    repeat (6) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    dat_i = b; wr_n = 1'b0; pause(); wr_n = 1'b1; pause();
  endtask

  task automatic rbit(output logic b);
    rd_n = 1'b0; pause(); rd_n = 1'b1; pause(); b = dat_o;
  endtask

  task automatic open_frame(input logic [2:0] code);
    cs_n = 1'b0; pause();
    for (int i = 2; i >= 0; i--) wbit(code[i]);
  endtask

  task automatic close_frame();
    cs_n = 1'b1; dat_i = 1'b1; pause();
  endtask

  task automatic send_addr(input logic [7:0] a);
    for (int i = 7; i >= 0; i--) wbit(a[i]);
  endtask

  task automatic send_nib(input logic [3:0] n);
    for (int i = 0; i < 4; i++) wbit(n[i]);
  endtask

  task automatic recv_nib(output logic [3:0] n);
    logic b;
    for (int i = 0; i < 4; i++) begin rbit(b); n[i] = b; end
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) wbit(c[i]);
    wbit(1'b1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int w0, c0;
    rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; dat_i = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0; pause();
    chk("R10 reset oe", dat_oe, 0);
    chk("R10 reset we", ram_we, 0);
    chk("R10 reset cmd", cmd_valid, 0);

    // table walk: write one nibble, then read it back (R2 R3 R6)
    foreach (VEC[k]) begin
      w0 = wcnt;
      open_frame(3'b101); send_addr(VEC[k][11:4]); send_nib(VEC[k][3:0]); close_frame();
      chk("R3 write count", wcnt, w0 + 1);
      chk("R3 write addr", lw_a, VEC[k][11:4]);
      chk("R3 write data", lw_d, VEC[k][3:0]);
      open_frame(3'b110);
      chk("R6 oe low in address", dat_oe, 0);
      send_addr(VEC[k][11:4]);
      chk("R6 oe high in data", dat_oe, 1);
      recv_nib(got);
      chk("R6 read nibble", got, VEC[k][3:0]);
      close_frame();
      chk("R6 oe low after select", dat_oe, 0);
    end

    // streaming write across the top of memory (R4 R5)
    w0 = wcnt;
    open_frame(3'b101); send_addr(8'hFE);
    send_nib(4'h1); send_nib(4'h2);
    chk("R5 last addr before wrap", lw_a, 8'hFF);
    send_nib(4'h3);
    chk("R5 wrap to zero", lw_a, 8'h00);
    chk("R4 stream data", lw_d, 4'h3);
    close_frame();
    chk("R4 stream count", wcnt, w0 + 3);
    open_frame(3'b110); send_addr(8'hFE);
    recv_nib(got); chk("R4 read stream 0", got, 4'h1);
    recv_nib(got); chk("R4 read stream 1", got, 4'h2);
    recv_nib(got); chk("R5 read after wrap", got, 4'h3);
    close_frame();

    // read-modify-write (R7)
    open_frame(3'b101); send_addr(8'h10); send_nib(4'h9); send_nib(4'h4); close_frame();
    open_frame(3'b101); send_addr(8'h10);
    recv_nib(got); chk("R7 rmw read 0", got, 4'h9);
    send_nib(4'hC);
    chk("R7 rmw same addr", lw_a, 8'h10);
    recv_nib(got); chk("R7 rmw read next", got, 4'h4);
    send_nib(4'hD);
    chk("R7 rmw next addr", lw_a, 8'h11);
    close_frame();
    open_frame(3'b110); send_addr(8'h10);
    recv_nib(got); chk("R7 readback 0", got, 4'hC);
    recv_nib(got); chk("R7 readback 1", got, 4'hD);
    close_frame();

    // commands, second without code (R8)
    c0 = ccnt;
    open_frame(3'b100);
    send_cmd(8'h03); chk("R8 cmd code 0", lc, 8'h03);
    send_cmd(8'hA5); chk("R8 cmd code 1", lc, 8'hA5);
    close_frame();
    chk("R8 cmd count", ccnt, c0 + 2);

    // aborted nibble and command (R9)
    w0 = wcnt; c0 = ccnt;
    open_frame(3'b101); send_addr(8'h20); wbit(1'b1); wbit(1'b1); close_frame();
    chk("R9 no partial write", wcnt, w0);
    open_frame(3'b100); for (int i = 0; i < 5; i++) wbit(1'b1); close_frame();
    chk("R9 no partial cmd", ccnt, c0);

    // strobes while deselected (R1) then a fresh frame
    for (int i = 0; i < 15; i++) wbit(i[0]);
    chk("R1 no write deselected", wcnt, w0);
    chk("R1 no cmd deselected", ccnt, c0);
    open_frame(3'b101); send_addr(8'h20); send_nib(4'h7); close_frame();
    chk("R1 new frame addr", lw_a, 8'h20);
    chk("R1 new frame data", lw_d, 4'h7);

    // unknown frame code ignored (R2)
    w0 = wcnt; c0 = ccnt;
    open_frame(3'b111); send_addr(8'h20); send_nib(4'h2); send_nib(4'h2); close_frame();
    chk("R2 bad code no write", wcnt, w0);
    chk("R2 bad code no cmd", ccnt, c0);

    finish_run();
  end

endmodule